// File: doc/BRIEF.md
# Per-Channel PCM Level Conditioning Path

This block sets the signal levels around one channel of a voice echo canceller. It works on 16-bit signed linear samples at the 8 kHz frame rate, and one strobe marks each frame. On the send side it scales the near-end input down before that input reaches the canceller. It then scales the canceller's residual up, can force very quiet residual samples to the smallest positive code, and can apply a 6 dB anti-howling cut. On the receive side it can pass samples through unchanged, apply a knee-type gain controller, or split a 6 dB cut before the canceller from a 6 dB restore after it.

Each decision that depends on level compares a short-term magnitude estimate with a threshold. The estimate comes in as an input, in the same linear units as the samples. The thresholds are derived from a parameter that gives the magnitude of 0 dBm0. Every control input is taken once per frame, together with the samples, so a setting can never change partway through the processing of a frame.

Top module: `pcm_level_cond`

## Requirements
- R1: The send-input cut code gives `sendToEc = sendIn >>> code`: code 0 is 0 dB, 1 is −6 dB, 2 is −12 dB and 3 is −18 dB. The shift is arithmetic, so it rounds toward minus infinity.
- R2: The send-output boost code gives `resIn <<< code` before any howling cut or clipping: code 0 is 0 dB, 1 is +6 dB, 2 is +12 dB and 3 is +18 dB. The result saturates to the range −32768..32767.
- R3: Receive code 2'b00 (off) and the reserved code 2'b10 pass `rxIn` unchanged to both `rxToEc` and `rxOut`.
- R4: Receive code 2'b01 selects the gain controller. With M20 = REF/10 and M115 = REF*266/1000 (integer division), a level below M20 passes the sample unchanged. A level in M20..M115, bounds included, gives `(rx*M20)/level`, truncated toward zero. A level above M115 gives `(rx*12315) >>> 15`, a cut of about 8.5 dB. The result drives both `rxToEc` and `rxOut`.
- R5: Receive code 2'b11 selects the paired limiter mode: `rxToEc = rxIn >>> 1` and `rxOut = 2*rxToEc`, so the level from end to end is unchanged.
- R6: With `clipEn` high, `sendOut` is 1 whenever `sendLevel < REF*2/1000` (−54 dBm0). This replaces the boosted and cut value. With `clipEn` low, no clipping takes place.
- R7: With `howlEn` high, exactly one 6 dB cut (`>>> 1`) is applied. It goes on `sendOut` when `rxActive` is high and `sendActive` is low. Otherwise, when neither flag is high or both are, it goes on `rxOut`. With `howlEn` low, neither output is cut.
- R8: Control codes, enables and activity flags are taken only in the strobe cycle. A change between strobes has no effect on the frame already in flight.
- R9: All outputs and `outValid` update on the second rising edge after a strobe is taken. `outValid` is high for that one cycle. The outputs hold their values until the next frame. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Frame strobe; samples, levels and controls are taken in this cycle |
| rxIn | input | 16 | Receive input sample, signed |
| sendIn | input | 16 | Send (near-end) input sample, signed |
| resIn | input | 16 | Canceller residual sample, signed |
| rxLevel | input | 16 | Receive magnitude estimate, unsigned |
| sendLevel | input | 16 | Send-output magnitude estimate, unsigned |
| rxActive | input | 1 | Receive path has activity |
| sendActive | input | 1 | Send path has activity |
| sendAttCode | input | 2 | Send-input cut code |
| sendGainCode | input | 2 | Send-output boost code |
| rxCtlCode | input | 2 | Receive level mode code |
| clipEn | input | 1 | Center clipper enable |
| howlEn | input | 1 | Anti-howling cut enable |
| outValid | output | 1 | One-cycle pulse when the outputs update |
| rxToEc | output | 16 | Conditioned receive sample that feeds the canceller reference |
| rxOut | output | 16 | Receive output sample |
| sendToEc | output | 16 | Cut send input that feeds the canceller |
| sendOut | output | 16 | Send output sample |

## Verification
Every result of a frame is due on the second rising edge after the strobe edge. The first edge takes the samples and controls, and the second edge registers the computed outputs together with `outValid`. The bench raises the strobe for one cycle and then waits two falling edges, so it samples at the falling edge just after the outputs settle. It also checks that `outValid` is high there and low one cycle later. For the latching test, it changes the codes between the two edges and expects the old settings to apply.

// File: rtl/lvl_pkg.sv
package lvl_pkg;

  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    RX_OFF = 2'b00,
    RX_GC  = 2'b01,
    RX_RSV = 2'b10,
    RX_LR  = 2'b11
  } rxMode_e;

  // strobes and selects from control to datapath
  typedef struct packed {
    logic              calc;
    logic [CODE_W-1:0] attShift;
    logic [CODE_W-1:0] gainShift;
    rxMode_e           rxMode;
    logic              clipOn;
    logic              howlSend;
    logic              howlRx;
  } lvlCtl_t;

endpackage

// File: rtl/lvl_control.sv
module lvl_control
  import lvl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [CODE_W-1:0] sendAttCode,
  input  logic [CODE_W-1:0] sendGainCode,
  input  logic [CODE_W-1:0] rxCtlCode,
  input  logic              clipEn,
  input  logic              howlEn,
  input  logic              rxActive,
  input  logic              sendActive,
  output lvlCtl_t           ctl
);

  logic [CODE_W-1:0] attQ, gainQ, rxCodeQ;
  logic clipQ, howlQ, rxActQ, sendActQ, calcQ;
  logic onlyRx;

  // controls are taken only with the frame strobe (R8)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attQ     <= '0;
      gainQ    <= '0;
      rxCodeQ  <= '0;
      clipQ    <= 1'b0;
      howlQ    <= 1'b0;
      rxActQ   <= 1'b0;
      sendActQ <= 1'b0;
      calcQ    <= 1'b0;
    end else begin
      calcQ <= sampleValid;
      if (sampleValid) begin
        attQ     <= sendAttCode;
        gainQ    <= sendGainCode;
        rxCodeQ  <= rxCtlCode;
        clipQ    <= clipEn;
        howlQ    <= howlEn;
        rxActQ   <= rxActive;
        sendActQ <= sendActive;
      end
    end
  end

  assign onlyRx = rxActQ & ~sendActQ;

  always_comb begin
    ctl.calc      = calcQ;
    ctl.attShift  = attQ;
    ctl.gainShift = gainQ;
    ctl.rxMode    = rxMode_e'(rxCodeQ);
    ctl.clipOn    = clipQ;
    ctl.howlSend  = howlQ & onlyRx;
    ctl.howlRx    = howlQ & ~onlyRx;
  end

  // R8: latched settings move only with a strobe
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable({attQ, gainQ, rxCodeQ, clipQ, howlQ, rxActQ, sendActQ}));

  // R7: exactly one anti-howling cut when enabled, none otherwise
  a_r7_one_cut: assert property (@(posedge clk) disable iff (!rstN)
    howlQ |-> ($countones({ctl.howlSend, ctl.howlRx}) == 1));

  a_r7_no_cut: assert property (@(posedge clk) disable iff (!rstN)
    !howlQ |-> !(ctl.howlSend || ctl.howlRx));

endmodule

// File: rtl/lvl_datapath.sv
module lvl_datapath
  import lvl_pkg::*;
#(
  parameter int W   = 16,
  parameter int LW  = 16,
  parameter int REF = 4000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  lvlCtl_t             ctl,
  input  logic signed [W-1:0] rxIn,
  input  logic signed [W-1:0] sendIn,
  input  logic signed [W-1:0] resIn,
  input  logic [LW-1:0]       rxLevel,
  input  logic [LW-1:0]       sendLevel,
  output logic                outValid,
  output logic signed [W-1:0] rxToEc,
  output logic signed [W-1:0] rxOut,
  output logic signed [W-1:0] sendToEc,
  output logic signed [W-1:0] sendOut
);

  localparam int NSTEP   = 2 ** CODE_W;
  localparam int GW      = W + NSTEP - 1;
  localparam int PW      = W + LW + 2;
  localparam int LVL_M20  = REF / 10;
  localparam int LVL_M115 = (REF * 266) / 1000;
  localparam int LVL_M54  = (REF * 2) / 1000;
  localparam int KNEE_Q  = 12315;
  localparam int KNEE_SH = 15;

  localparam logic signed [GW-1:0] HI = GW'((2 ** (W - 1)) - 1);
  localparam logic signed [GW-1:0] LO = -HI - GW'(1);
  localparam logic signed [PW-1:0] M20S  = PW'(LVL_M20);
  localparam logic signed [PW-1:0] KNEES = PW'(KNEE_Q);
  localparam logic [LW-1:0] M20L  = LW'(LVL_M20);
  localparam logic [LW-1:0] M115L = LW'(LVL_M115);
  localparam logic [LW-1:0] M54L  = LW'(LVL_M54);

  function automatic logic signed [W-1:0] satW(input logic signed [GW-1:0] v);
    if (v > HI)      return HI[W-1:0];
    else if (v < LO) return LO[W-1:0];
    else             return v[W-1:0];
  endfunction

  // input stage, taken with the strobe
  logic signed [W-1:0] rxQ, sendQ, resQ;
  logic [LW-1:0] rxLvlQ, sendLvlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxQ      <= '0;
      sendQ    <= '0;
      resQ     <= '0;
      rxLvlQ   <= '0;
      sendLvlQ <= '0;
    end else if (sampleValid) begin
      rxQ      <= rxIn;
      sendQ    <= sendIn;
      resQ     <= resIn;
      rxLvlQ   <= rxLevel;
      sendLvlQ <= sendLevel;
    end
  end

  // send-output boost: one saturating tap per code value (R2)
  logic signed [GW-1:0] resExt;
  logic signed [W-1:0]  gainTap [NSTEP];
  assign resExt = {{(GW-W){resQ[W-1]}}, resQ};

  for (genvar k = 0; k < NSTEP; k++) begin : g_gain
    assign gainTap[k] = satW(resExt <<< k);
  end

  // receive gain controller (R4)
  logic signed [PW-1:0] rxExt, lvlDiv, prodM20, prodKnee, gcRaw;
  logic signed [W-1:0]  rxGc;
  assign rxExt    = {{(PW-W){rxQ[W-1]}}, rxQ};
  assign lvlDiv   = (rxLvlQ == '0) ? PW'(1) : {{(PW-LW){1'b0}}, rxLvlQ};
  assign prodM20  = rxExt * M20S;
  assign prodKnee = rxExt * KNEES;

  always_comb begin
    if (rxLvlQ > M115L)       gcRaw = prodKnee >>> KNEE_SH;
    else if (rxLvlQ >= M20L)  gcRaw = prodM20 / lvlDiv;
    else                      gcRaw = rxExt;
    rxGc = gcRaw[W-1:0];
  end

  logic signed [W-1:0] refN, postN, rxOutN, sendToEcN, boosted, cutSend, sendOutN;

  always_comb begin
    unique case (ctl.rxMode)
      RX_GC: begin
        refN  = rxGc;
        postN = rxGc;
      end
      RX_LR: begin
        refN  = rxQ >>> 1;
        postN = satW({{(GW-W){refN[W-1]}}, refN} <<< 1);
      end
      default: begin
        refN  = rxQ;
        postN = rxQ;
      end
    endcase
    rxOutN = ctl.howlRx ? (postN >>> 1) : postN;

    sendToEcN = sendQ >>> ctl.attShift;
    boosted   = gainTap[ctl.gainShift];
    cutSend   = ctl.howlSend ? (boosted >>> 1) : boosted;
    if (ctl.clipOn && (sendLvlQ < M54L))
      sendOutN = {{(W-1){1'b0}}, 1'b1};
    else
      sendOutN = cutSend;
  end

  // output stage, one cycle after the strobe cycle (R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      rxToEc   <= '0;
      rxOut    <= '0;
      sendToEc <= '0;
      sendOut  <= '0;
    end else begin
      outValid <= ctl.calc;
      if (ctl.calc) begin
        rxToEc   <= refN;
        rxOut    <= rxOutN;
        sendToEc <= sendToEcN;
        sendOut  <= sendOutN;
      end
    end
  end

  a_r9_latency: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> ##1 outValid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.calc |=> (!outValid && $stable(sendOut) && $stable(rxOut)
                   && $stable(rxToEc) && $stable(sendToEc)));

  a_r6_clip: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.calc && ctl.clipOn && (sendLvlQ < M54L)) |=> (sendOut == W'(1)));

  a_r5_lr_pair: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.calc && (ctl.rxMode == RX_LR) && !ctl.howlRx) |=>
      (rxOut == {rxToEc[W-2:0], 1'b0}));

endmodule

// File: rtl/pcm_level_cond.sv
module pcm_level_cond #(
  parameter int W   = 16,
  parameter int LW  = 16,
  parameter int REF = 4000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic signed [W-1:0] rxIn,
  input  logic signed [W-1:0] sendIn,
  input  logic signed [W-1:0] resIn,
  input  logic [LW-1:0]       rxLevel,
  input  logic [LW-1:0]       sendLevel,
  input  logic                rxActive,
  input  logic                sendActive,
  input  logic [1:0]          sendAttCode,
  input  logic [1:0]          sendGainCode,
  input  logic [1:0]          rxCtlCode,
  input  logic                clipEn,
  input  logic                howlEn,
  output logic                outValid,
  output logic signed [W-1:0] rxToEc,
  output logic signed [W-1:0] rxOut,
  output logic signed [W-1:0] sendToEc,
  output logic signed [W-1:0] sendOut
);

  lvl_pkg::lvlCtl_t ctl;

  lvl_control u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .sendAttCode  (sendAttCode),
    .sendGainCode (sendGainCode),
    .rxCtlCode    (rxCtlCode),
    .clipEn       (clipEn),
    .howlEn       (howlEn),
    .rxActive     (rxActive),
    .sendActive   (sendActive),
    .ctl          (ctl)
  );

  lvl_datapath #(.W(W), .LW(LW), .REF(REF)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .ctl         (ctl),
    .rxIn        (rxIn),
    .sendIn      (sendIn),
    .resIn       (resIn),
    .rxLevel     (rxLevel),
    .sendLevel   (sendLevel),
    .outValid    (outValid),
    .rxToEc      (rxToEc),
    .rxOut       (rxOut),
    .sendToEc    (sendToEc),
    .sendOut     (sendOut)
  );

endmodule

// File: tb/pcm_level_cond_tb.sv
`timescale 1ns/1ps
module pcm_level_cond_tb;

  localparam int REF = 4000;
  localparam int M20 = REF / 10;
  localparam int M115 = (REF * 266) / 1000;
  localparam int M54 = (REF * 2) / 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [15:0] rxIn, sendIn, resIn;
  logic [15:0] rxLevel, sendLevel;
  logic rxActive, sendActive, clipEn, howlEn;
  logic [1:0] sendAttCode, sendGainCode, rxCtlCode;
  logic outValid;
  logic signed [15:0] rxToEc, rxOut, sendToEc, sendOut;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcm_level_cond u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .rxIn(rxIn), .sendIn(sendIn), .resIn(resIn),
    .rxLevel(rxLevel), .sendLevel(sendLevel),
    .rxActive(rxActive), .sendActive(sendActive),
    .sendAttCode(sendAttCode), .sendGainCode(sendGainCode), .rxCtlCode(rxCtlCode),
    .clipEn(clipEn), .howlEn(howlEn),
    .outValid(outValid), .rxToEc(rxToEc), .rxOut(rxOut),
    .sendToEc(sendToEc), .sendOut(sendOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int expGc(input int rx, input int lvl);
    if (lvl > M115) return (rx * 12315) >>> 15;
    if (lvl >= M20) return (rx * M20) / lvl;
    return rx;
  endfunction

  task automatic defaults();
    rxIn = 0; sendIn = 0; resIn = 0;
    rxLevel = 16'd1000; sendLevel = 16'd1000;
    rxActive = 0; sendActive = 0;
    sendAttCode = 0; sendGainCode = 0; rxCtlCode = 0;
    clipEn = 0; howlEn = 0;
  endtask

  // strobe one frame; return at the falling edge after the outputs update
  task automatic fire();
    @(negedge clk); sampleValid = 1'b1;
    @(negedge clk); sampleValid = 1'b0;
    @(negedge clk);
    chk("R9 outValid pulse", int'(outValid), 1);
  endtask

  task automatic t_reset();
    chk("R9 reset sendOut", int'(sendOut), 0);
    chk("R9 reset rxOut", int'(rxOut), 0);
    chk("R9 reset rxToEc", int'(rxToEc), 0);
    chk("R9 reset sendToEc", int'(sendToEc), 0);
    chk("R9 reset outValid", int'(outValid), 0);
  endtask

  task automatic t_send_att();
    defaults();
    for (int c = 0; c < 4; c++) begin
      sendIn = -16'sd1001; sendAttCode = 2'(c);
      fire();
      chk("R1 send cut", int'(sendToEc), (-1001) >>> c);
    end
    sendIn = 16'sd1000; sendAttCode = 2'd3;
    fire();
    chk("R1 send cut positive", int'(sendToEc), 125);
  endtask

  task automatic t_send_gain();
    defaults();
    for (int c = 0; c < 4; c++) begin
      resIn = 16'sd3000; sendGainCode = 2'(c);
      fire();
      chk("R2 send boost", int'(sendOut), 3000 << c);
    end
    resIn = 16'sd5000; sendGainCode = 2'd3;
    fire();
    chk("R2 boost saturates high", int'(sendOut), sat16(40000));
    resIn = -16'sd5000;
    fire();
    chk("R2 boost saturates low", int'(sendOut), -32768);
  endtask

  task automatic t_rx_pass();
    defaults();
    rxIn = -16'sd1234; rxCtlCode = 2'b00;
    fire();
    chk("R3 off rxOut", int'(rxOut), -1234);
    chk("R3 off rxToEc", int'(rxToEc), -1234);
    rxCtlCode = 2'b10; rxIn = 16'sd777; rxLevel = 16'd3000;
    fire();
    chk("R3 reserved rxOut", int'(rxOut), 777);
    chk("R3 reserved rxToEc", int'(rxToEc), 777);
  endtask

  task automatic t_gc();
    int lv [5] = '{300, M20, 800, M115, 2000};
    int sm [5] = '{2000, 2000, 2000, 2000, -3000};
    defaults();
    rxCtlCode = 2'b01;
    for (int i = 0; i < 5; i++) begin
      rxIn = 16'(sm[i]); rxLevel = 16'(lv[i]);
      fire();
      chk("R4 gc rxOut", int'(rxOut), expGc(sm[i], lv[i]));
      chk("R4 gc rxToEc", int'(rxToEc), expGc(sm[i], lv[i]));
    end
  endtask

  task automatic t_lr();
    defaults();
    rxCtlCode = 2'b11;
    rxIn = -16'sd1001;
    fire();
    chk("R5 lr rxToEc", int'(rxToEc), -501);
    chk("R5 lr rxOut", int'(rxOut), -1002);
    rxIn = 16'sd32767;
    fire();
    chk("R5 lr rxOut max", int'(rxOut), 32766);
  endtask

  task automatic t_clip();
    defaults();
    clipEn = 1; resIn = -16'sd40; sendLevel = 16'(M54 - 1);
    fire();
    chk("R6 clip below", int'(sendOut), 1);
    sendLevel = 16'(M54);
    fire();
    chk("R6 clip at threshold", int'(sendOut), -40);
    clipEn = 0; sendLevel = 16'd0;
    fire();
    chk("R6 clip off", int'(sendOut), -40);
  endtask

  task automatic t_howl();
    defaults();
    howlEn = 1; resIn = 16'sd800; rxIn = 16'sd600;
    rxActive = 1; sendActive = 0;
    fire();
    chk("R7 rx only sendOut cut", int'(sendOut), 400);
    chk("R7 rx only rxOut full", int'(rxOut), 600);
    rxActive = 1; sendActive = 1;
    fire();
    chk("R7 both sendOut full", int'(sendOut), 800);
    chk("R7 both rxOut cut", int'(rxOut), 300);
    rxActive = 0; sendActive = 0;
    fire();
    chk("R7 idle rxOut cut", int'(rxOut), 300);
    howlEn = 0; rxActive = 1;
    fire();
    chk("R7 off sendOut", int'(sendOut), 800);
    chk("R7 off rxOut", int'(rxOut), 600);
  endtask

  task automatic t_latch();
    defaults();
    sendIn = 16'sd800; resIn = 16'sd100; sendAttCode = 2'd1; sendGainCode = 2'd1;
    @(negedge clk); sampleValid = 1'b1;
    @(negedge clk); sampleValid = 1'b0;
    sendAttCode = 2'd3; sendGainCode = 2'd3; sendIn = 16'sd0;
    @(negedge clk);
    chk("R8 cut code latched", int'(sendToEc), 400);
    chk("R8 boost code latched", int'(sendOut), 200);
    repeat (4) @(negedge clk);
    chk("R9 hold sendToEc", int'(sendToEc), 400);
    chk("R9 outValid low between frames", int'(outValid), 0);
    sendIn = 16'sd800;
    fire();
    chk("R8 new code next frame", int'(sendToEc), 100);
    chk("R8 new boost next frame", int'(sendOut), 800);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog R9 actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_send_att();
    t_send_gain();
    t_rx_pass();
    t_gc();
    t_lr();
    t_clip();
    t_howl();
    t_latch();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule